// File: doc/BRIEF.md
# Zero-Crossing Interval Phase Detector

This block measures the phase offset between an intermediate-frequency signal and a reference waveform of the same frequency. Both arrive as single-bit, hard-limited inputs. Each input is synchronised into the fast system clock domain, and the selected crossing polarity is picked out on each of them. A crossing on the signal opens a measurement window, which is held in a set/reset flag. A crossing on the reference closes the window. While the window is open, a counter advances once per system clock. When the window closes, the count is stored as a binary phase word and a one-cycle strobe goes out with it.

The phase word is the number of system clock cycles between the two crossings. One input period therefore spans (system clock frequency / IF frequency) counts, and that ratio is the resolution. A tracker-driven range gate enables measurement. Outside the gate, crossings are ignored and any partly measured window is thrown away. A programmable limit raises an overflow flag when a window stays open too long. The counter saturates instead of wrapping.

Top module: `zc_phase_det`

## Requirements
- R1: After reset, phase_word is 0, phase_vld is 0 and ovf_flag is 0.
- R2: With the rising polarity (parameter POL = ZC_RISE, encoding 0), a 0-to-1 change on sig_in followed D clock cycles later by a 0-to-1 change on ref_in yields phase_word = D. The word and a phase_vld pulse appear two clock edges after the edge that first samples the reference change.
- R3: With POL = ZC_FALL (encoding 1), only 1-to-0 changes count as crossings, and 0-to-1 changes have no effect.
- R4: phase_vld is high for exactly one cycle per completed measurement, and phase_word holds its value until the next completed measurement.
- R5: When signal and reference crossings are detected in the same cycle, phase_word becomes 0 with a phase_vld pulse and no new window is opened.
- R6: The count saturates at 2^CNT_W-1, and a window longer than that reports 2^CNT_W-1.
- R7: ovf_flag is high while an open window has counted at least period_lim cycles. It is low once the window closes or is discarded.
- R8: While gate_en is low, the window is cleared and crossings are ignored. A window cut short by the gate produces no phase_vld.
- R9: A reference crossing with no open window has no effect.
- R10: A signal crossing while a window is already open restarts the count from that crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast measurement clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_in | input | 1 | Hard-limited IF signal |
| ref_in | input | 1 | Hard-limited reference waveform |
| gate_en | input | 1 | Range gate from the tracker, high enables measurement |
| period_lim | input | CNT_W | Cycle count at which an open window flags overflow |
| phase_word | output | CNT_W | Last measured phase, in clock cycles |
| phase_vld | output | 1 | One-cycle strobe for a new phase_word |
| ovf_flag | output | 1 | Open window has reached period_lim |

## Verification
The opening and closing of a window can fall in the same cycle. The bench provokes this by raising both inputs on the same clock, which makes the two synchronised edges coincide. The scoreboard then expects a zero phase word. It also watches the following measurements to confirm that no stray window was opened, because a leftover open window would produce a spurious strobe that the monitor flags. Saturation and gate truncation are also run against the queue of expected words, so any unexpected strobe or wrong value shows up as a mismatch.

// File: rtl/zc_pkg.sv
package zc_pkg;
  typedef enum logic {ZC_RISE = 1'b0, ZC_FALL = 1'b1} zc_pol_e;

  // crossing of the selected polarity between two successive samples
  function automatic logic crossing(input logic cur, input logic prev, input zc_pol_e pol);
    return (pol == ZC_RISE) ? (cur & ~prev) : (~cur & prev);
  endfunction
endpackage

// File: rtl/zc_edge_det.sv
module zc_edge_det
  import zc_pkg::*;
#(
  parameter int      SYNC_STAGES = 2,
  parameter zc_pol_e POL         = ZC_RISE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      prev_q <= cur;
    end
  end

  assign edge_o = crossing(cur, prev_q, POL);
endmodule

// File: rtl/zc_interval.sv
module zc_interval #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_en,
  input  logic             sig_ev,
  input  logic             ref_ev,
  input  logic [CNT_W-1:0] period_lim,
  output logic             armed_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             close_o,
  output logic [CNT_W-1:0] close_val_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? CNT_MAX : v + 1'b1;
  endfunction

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;

  // reference closes an open window, or a window opened this very cycle
  assign close_o     = ref_ev & (armed_q | sig_ev);
  assign close_val_o = sig_ev ? '0 : sat_inc(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!gate_en || close_o) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (sig_ev) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q) begin
      cnt_q   <= sat_inc(cnt_q);
    end
  end

  assign armed_o = armed_q;
  assign cnt_o   = cnt_q;
  assign ovf_o   = armed_q & (cnt_q >= period_lim);
endmodule

// File: rtl/zc_phase_reg.sv
module zc_phase_reg #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] val,
  output logic [CNT_W-1:0] word_o,
  output logic             vld_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= load;
      if (load) word_o <= val;
    end
  end
endmodule

// File: rtl/zc_phase_det.sv
module zc_phase_det
  import zc_pkg::*;
#(
  parameter int      CNT_W       = 10,
  parameter int      SYNC_STAGES = 2,
  parameter zc_pol_e POL         = ZC_RISE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic             ref_in,
  input  logic             gate_en,
  input  logic [CNT_W-1:0] period_lim,
  output logic [CNT_W-1:0] phase_word,
  output logic             phase_vld,
  output logic             ovf_flag
);
  logic             sig_edge, ref_edge;
  logic             sig_ev, ref_ev;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic             close_ev;
  logic [CNT_W-1:0] close_val;

  zc_edge_det #(.SYNC_STAGES(SYNC_STAGES), .POL(POL)) u_sig_edge (
    .clk(clk), .rst_n(rst_n), .din(sig_in), .edge_o(sig_edge)
  );
  zc_edge_det #(.SYNC_STAGES(SYNC_STAGES), .POL(POL)) u_ref_edge (
    .clk(clk), .rst_n(rst_n), .din(ref_in), .edge_o(ref_edge)
  );

  // crossings count only inside the range gate
  assign sig_ev = sig_edge & gate_en;
  assign ref_ev = ref_edge & gate_en;

  zc_interval #(.CNT_W(CNT_W)) u_interval (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en),
    .sig_ev(sig_ev), .ref_ev(ref_ev), .period_lim(period_lim),
    .armed_o(armed), .cnt_o(cnt), .close_o(close_ev),
    .close_val_o(close_val), .ovf_o(ovf_flag)
  );

  zc_phase_reg #(.CNT_W(CNT_W)) u_phase_reg (
    .clk(clk), .rst_n(rst_n), .load(close_ev), .val(close_val),
    .word_o(phase_word), .vld_o(phase_vld)
  );
endmodule

// File: rtl/zc_phase_det_chk.sv
module zc_phase_det_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate_en,
  input logic             sig_ev,
  input logic             ref_ev,
  input logic             armed,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] phase_word,
  input logic             phase_vld,
  input logic             ovf_flag
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R4
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_vld |=> !phase_vld);
  // R4
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_vld |-> $stable(phase_word));
  // R5
  coincide_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_ev && ref_ev) |=> (phase_vld && phase_word == '0 && !armed));
  // R8
  gate_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> (!armed && cnt == '0 && !phase_vld));
  // R6
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && armed && cnt == CNT_MAX && !sig_ev && !ref_ev) |=> cnt == CNT_MAX);
  // R9
  stray_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_ev && !armed && !sig_ev) |=> !phase_vld);
  // R7
  ovf_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |-> armed);
endmodule

bind zc_phase_det zc_phase_det_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .sig_ev(sig_ev),
  .ref_ev(ref_ev), .armed(armed), .cnt(cnt), .phase_word(phase_word),
  .phase_vld(phase_vld), .ovf_flag(ovf_flag)
);

// File: tb/zc_phase_det_tb.sv
module zc_phase_det_tb;
  import zc_pkg::*;
  localparam int CW = 6;
  localparam logic [CW-1:0] SAT = {CW{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sig_in = 1'b0, ref_in = 1'b0, gate_en = 1'b0;
  logic [CW-1:0] period_lim = CW'(20);
  logic [CW-1:0] phase_word, phase_word_f;
  logic phase_vld, phase_vld_f, ovf_flag, ovf_flag_f;

  int n_chk = 0, n_bad = 0;
  logic [CW-1:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  zc_phase_det #(.CNT_W(CW), .POL(ZC_RISE)) u_dut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .ref_in(ref_in),
    .gate_en(gate_en), .period_lim(period_lim),
    .phase_word(phase_word), .phase_vld(phase_vld), .ovf_flag(ovf_flag));

  zc_phase_det #(.CNT_W(CW), .POL(ZC_FALL)) u_dut_f (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .ref_in(ref_in),
    .gate_en(gate_en), .period_lim(period_lim),
    .phase_word(phase_word_f), .phase_vld(phase_vld_f), .ovf_flag(ovf_flag_f));

  task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected window length: cycles between the two input changes
  function automatic logic [CW-1:0] expect_word(input int d);
    return (d >= int'(SAT)) ? SAT : CW'(d);
  endfunction

  // driver: one signal crossing, a reference crossing d cycles later
  task automatic measure(input string req, input int d);
    exp_q.push_back(expect_word(d));
    tag_q.push_back(req);
    sig_in = 1'b1;
    if (d == 0) ref_in = 1'b1;
    else begin cyc(d); ref_in = 1'b1; end
    cyc(8);
    sig_in = 1'b0; ref_in = 1'b0;
    cyc(6);
  endtask

  // monitor: pops expected words as strobes appear
  always @(negedge clk) begin
    if (rst_n && phase_vld) begin
      if (exp_q.size() == 0) check("R8/R9 unexpected strobe", phase_word, 'x);
      else check(tag_q.pop_front(), phase_word, exp_q.pop_front());
    end
  end

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    check("R1 word", phase_word, '0);
    check("R1 vld", CW'(phase_vld), '0);
    check("R1 ovf", CW'(ovf_flag), '0);
    gate_en = 1'b1;
    cyc(4);

    // R2 several window lengths
    measure("R2 d=1", 1);
    measure("R2 d=7", 7);
    measure("R2 d=25", 25);

    // R4 word held long after the strobe
    cyc(20);
    check("R4 hold", phase_word, CW'(25));

    // R5 both crossings together, then a normal one proves no stray window
    measure("R5 coincide", 0);
    measure("R5 after coincide", 4);

    // R9 reference alone: no strobe (monitor flags any)
    ref_in = 1'b1; cyc(10); ref_in = 1'b0; cyc(6);
    check("R9 word unchanged", phase_word, CW'(4));

    // R10 restart on a second signal crossing
    exp_q.push_back(CW'(7)); tag_q.push_back("R10 restart");
    sig_in = 1'b1; cyc(4); sig_in = 1'b0; cyc(4); sig_in = 1'b1; cyc(7);
    ref_in = 1'b1; cyc(8); sig_in = 1'b0; ref_in = 1'b0; cyc(6);

    // R6/R7 long window saturates and flags overflow
    exp_q.push_back(SAT); tag_q.push_back("R6 saturate");
    sig_in = 1'b1;
    cyc(10);
    check("R7 ovf low early", CW'(ovf_flag), '0);
    cyc(20);
    check("R7 ovf high", CW'(ovf_flag), CW'(1));
    cyc(50);
    ref_in = 1'b1;
    cyc(5);
    check("R7 ovf cleared", CW'(ovf_flag), '0);
    cyc(3); sig_in = 1'b0; ref_in = 1'b0; cyc(6);

    // R8 gate drop discards a partial window
    sig_in = 1'b1; cyc(10);
    gate_en = 1'b0; cyc(5);
    check("R8 ovf low gated", CW'(ovf_flag), '0);
    gate_en = 1'b1; cyc(5);
    ref_in = 1'b1; cyc(10);
    check("R8 word unchanged", phase_word, SAT);
    sig_in = 1'b0; ref_in = 1'b0; cyc(6);
    // R8 signal crossing outside the gate is ignored
    gate_en = 1'b0; sig_in = 1'b1; cyc(6);
    gate_en = 1'b1; cyc(3); ref_in = 1'b1; cyc(10);
    check("R8 gated crossing ignored", phase_word, SAT);
    sig_in = 1'b0; ref_in = 1'b0; cyc(6);

    // R3 falling polarity instance; rising one sees a coincidence first
    exp_q.push_back('0); tag_q.push_back("R3 rise coincide");
    sig_in = 1'b1; ref_in = 1'b1; cyc(8);
    sig_in = 1'b0; cyc(30); ref_in = 1'b0; cyc(8);
    check("R3 falling word", phase_word_f, CW'(30));
    check("R3 rising unaffected", phase_word, '0);

    cyc(10);
    check("R4 queue drained", CW'(exp_q.size()), '0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule